// File: doc/BRIEF.md
# Coincident-Current Core Memory Access Sequencer

This block is the digital side of a 32K-word magnetic core store built in the two-and-a-half-dimension style with three wires per core. It accepts one word access at a time through a valid/ready handshake. From the latched 15-bit word address it drives one-hot select vectors: three 1-of-8 groups for the shared Y-axis drive matrices, one shared 1-of-8 X row group, and one 1-of-8 X column group for each of the 20 bit-arrays. It also drives a Y drive-direction line and a 1-of-8 sense-group select. The analog drivers, pulse transformers, sense amplifiers and cores are outside the block.

A read destroys the addressed word, so every access is one fixed sequence of phases: a read drive, a sense strobe, a write drive and a recovery. A read request writes back what it sensed. A write request senses the old word, drops it, and then writes the new data. No inhibit wire exists. During the write drive, each bit-array's X column decoder is enabled only where the stored bit is a one. Even parity over the 18 data bits goes into bit-array 18 on writes and is checked on reads. Bit-array 19 is a spare and is never driven.

Top module: `core_cycle_ctrl`

## Requirements
- R1: `req_ready` is high only while the block is idle, and it drops in the cycle after a request is taken. `done` is a one-cycle pulse. It is seen exactly T_RD+T_SS+T_WR+T_RC clock edges after the edge that took the request (10 with the default parameters).
- R2: The address splits, from the top, into three 3-bit Y fields and then two 3-bit X fields: row = addr[14:12], column = addr[11:9], vector = addr[8:6]. In the read drive, `y_row_sel`, `y_col_sel` and `y_vec_sel` are the one-hot decodes of these fields, with bit n set for field value n.
- R3: In both drive phases, `x_row_sel` is the one-hot decode of addr[5:3]. Every enabled bit-array select `x_arr_sel[8*i+7:8*i]` is the one-hot decode of addr[2:0].
- R4: `y_dir` is 0 throughout the read drive and 1 throughout the write drive. The read drive always comes first.
- R5: During the write drive, `y_col_sel` decodes the column field with its lowest bit inverted (column XOR 1). This swaps the two columns of each pair.
- R6: In the read drive, bit-arrays 0 to 18 are all enabled. In the write drive, bit-array i is enabled only when bit i of the word being stored is one. Bits 0 to 17 are the data and bit 18 is the parity.
- R7: `sense_sel` is the one-hot decode of addr[14:12]. It is active only during the sense strobe and never while a drive select is active.
- R8: A read returns the stored 18 data bits on `rd_data` with `done`, and it writes the sensed word back, so a second read returns the same value.
- R9: A write replaces the whole old word. Afterwards the location holds the new data in bits 17:0 and even parity (XOR of the data bits) in bit 18.
- R10: On a read, `parity_error` is 1 with `done` exactly when the sensed bits 18:0 hold an odd number of ones. On a write it is 0. A word with bad parity is written back unchanged.
- R11: All select outputs are zero outside their own phases, and no select group ever has more than one line active.
- R12: The spare bit-array 19 is never selected in any phase, and its content has no effect on `rd_data` or `parity_error`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request |
| req_ready | output | 1 | Block idle, request will be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 15 | Word address |
| req_wdata | input | 18 | Write data |
| done | output | 1 | One-cycle end-of-access pulse |
| rd_data | output | 18 | Data read, valid with done |
| parity_error | output | 1 | Read parity mismatch, valid with done |
| y_row_sel | output | 8 | First Y matrix row group |
| y_col_sel | output | 8 | First Y matrix column group (crossed over on write) |
| y_vec_sel | output | 8 | Second Y matrix 8-wide axis |
| y_dir | output | 1 | Y drive direction, 1 = write |
| x_row_sel | output | 8 | X row group shared by all bit-arrays |
| x_arr_sel | output | 160 | Per-bit-array X column group, 8 lines each |
| sense_sel | output | 8 | Sense-group select |
| sense_bits | input | 19 | Sense amplifier outputs, bit-arrays 0 to 18 |

## Verification
The bench models the cores as a store that is cleared by the read drive and set by the write drive, and it decodes addresses only from the select lines. A design that leaves out the write crossover, or that inverts the drive direction, writes the data to a different word, so the next read returns the wrong value. A design that drives the column enables from the written data alone, rather than from data plus parity, loses the parity bit and reports false parity errors. One that forgets the restore reads zeros the second time. The bench also sets the spare bit, flips a stored bit and uses the lowest and highest addresses, to catch a spare that leaks into parity and to catch field slices that are off by one.

// File: rtl/core_ctrl_pkg.sv
package core_ctrl_pkg;
  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_RD   = 3'd1,
    PH_SS   = 3'd2,
    PH_WR   = 3'd3,
    PH_RC   = 3'd4
  } phase_t;
endpackage

// File: rtl/core_sel_dec.sv
module core_sel_dec #(
  parameter int CODE_W = 3
) (
  input  logic                     en,
  input  logic [CODE_W-1:0]        code,
  output logic [(1<<CODE_W)-1:0]   sel
);
  localparam int N = 1 << CODE_W;

  for (genvar i = 0; i < N; i++) begin : g_line
    assign sel[i] = en && (code == CODE_W'(i));
  end
endmodule

// File: rtl/core_phase_seq.sv
module core_phase_seq
  import core_ctrl_pkg::*;
#(
  parameter int T_RD = 3,
  parameter int T_SS = 2,
  parameter int T_WR = 3,
  parameter int T_RC = 2
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   start,
  output phase_t phase,
  output logic   last,
  output logic   done
);
  localparam int M_A   = (T_RD > T_SS) ? T_RD : T_SS;
  localparam int M_B   = (T_WR > T_RC) ? T_WR : T_RC;
  localparam int MAXT  = (M_A > M_B) ? M_A : M_B;
  localparam int CNT_W = $clog2(MAXT + 1);

  logic [CNT_W-1:0] cnt, len;

  always_comb begin
    case (phase)
      PH_RD:   len = CNT_W'(T_RD);
      PH_SS:   len = CNT_W'(T_SS);
      PH_WR:   len = CNT_W'(T_WR);
      PH_RC:   len = CNT_W'(T_RC);
      default: len = CNT_W'(1);
    endcase
  end

  assign last = (phase != PH_IDLE) && (cnt == len - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_IDLE;
      cnt   <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (phase == PH_IDLE) begin
        cnt <= '0;
        if (start) phase <= PH_RD;
      end else if (last) begin
        cnt <= '0;
        case (phase)
          PH_RD:   phase <= PH_SS;
          PH_SS:   phase <= PH_WR;
          PH_WR:   phase <= PH_RC;
          default: begin
            phase <= PH_IDLE;
            done  <= 1'b1;
          end
        endcase
      end else begin
        cnt <= cnt + CNT_W'(1);
      end
    end
  end

  assert_done_pulse_R1: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_done_idle_R1: assert property (@(posedge clk) disable iff (rst)
    done |-> (phase == PH_IDLE));
  assert_cnt_range_R1: assert property (@(posedge clk) disable iff (rst)
    (phase != PH_IDLE) |-> (cnt < len));
endmodule

// File: rtl/core_cycle_ctrl.sv
module core_cycle_ctrl
  import core_ctrl_pkg::*;
#(
  parameter int FIELD_W = 3,
  parameter int DATA_W  = 18,
  parameter int T_RD    = 3,
  parameter int T_SS    = 2,
  parameter int T_WR    = 3,
  parameter int T_RC    = 2
) (
  input  logic                                   clk,
  input  logic                                   rst,
  input  logic                                   req_valid,
  output logic                                   req_ready,
  input  logic                                   req_write,
  input  logic [5*FIELD_W-1:0]                   req_addr,
  input  logic [DATA_W-1:0]                      req_wdata,
  output logic                                   done,
  output logic [DATA_W-1:0]                      rd_data,
  output logic                                   parity_error,
  output logic [(1<<FIELD_W)-1:0]                y_row_sel,
  output logic [(1<<FIELD_W)-1:0]                y_col_sel,
  output logic [(1<<FIELD_W)-1:0]                y_vec_sel,
  output logic                                   y_dir,
  output logic [(1<<FIELD_W)-1:0]                x_row_sel,
  output logic [(DATA_W+2)*(1<<FIELD_W)-1:0]     x_arr_sel,
  output logic [(1<<FIELD_W)-1:0]                sense_sel,
  input  logic [DATA_W:0]                        sense_bits
);
  localparam int ADDR_W = 5 * FIELD_W;
  localparam int SEL_W  = 1 << FIELD_W;
  localparam int NBITS  = DATA_W + 2;
  localparam int SPARE  = DATA_W + 1;
  localparam int YR_HI  = ADDR_W - 1;
  localparam int YC_HI  = ADDR_W - 1 - FIELD_W;
  localparam int YV_HI  = ADDR_W - 1 - 2 * FIELD_W;
  localparam int XR_HI  = 2 * FIELD_W - 1;
  localparam int XC_HI  = FIELD_W - 1;

  phase_t phase;
  logic   last;

  logic [ADDR_W-1:0] addr_q;
  logic              wr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W:0]   word_q;   // data + parity to be put back

  logic start, rd_ph, wr_ph, drv;
  logic [FIELD_W-1:0] col_code;

  assign req_ready = (phase == PH_IDLE);
  assign start     = req_valid && req_ready;
  assign rd_ph     = (phase == PH_RD);
  assign wr_ph     = (phase == PH_WR);
  assign drv       = rd_ph || wr_ph;
  assign y_dir     = wr_ph;
  assign col_code  = addr_q[YC_HI -: FIELD_W] ^ FIELD_W'(wr_ph);

  core_phase_seq #(
    .T_RD(T_RD), .T_SS(T_SS), .T_WR(T_WR), .T_RC(T_RC)
  ) u_seq (
    .clk(clk), .rst(rst), .start(start),
    .phase(phase), .last(last), .done(done)
  );

  core_sel_dec #(.CODE_W(FIELD_W)) u_dec_yrow (
    .en(drv), .code(addr_q[YR_HI -: FIELD_W]), .sel(y_row_sel));
  core_sel_dec #(.CODE_W(FIELD_W)) u_dec_ycol (
    .en(drv), .code(col_code), .sel(y_col_sel));
  core_sel_dec #(.CODE_W(FIELD_W)) u_dec_yvec (
    .en(drv), .code(addr_q[YV_HI -: FIELD_W]), .sel(y_vec_sel));
  core_sel_dec #(.CODE_W(FIELD_W)) u_dec_xrow (
    .en(drv), .code(addr_q[XR_HI -: FIELD_W]), .sel(x_row_sel));
  core_sel_dec #(.CODE_W(FIELD_W)) u_dec_sense (
    .en(phase == PH_SS), .code(addr_q[YR_HI -: FIELD_W]), .sel(sense_sel));

  for (genvar i = 0; i < NBITS; i++) begin : g_arr
    logic arr_en;
    if (i == SPARE) begin : g_spare
      assign arr_en = 1'b0;
    end else begin : g_used
      assign arr_en = rd_ph || (wr_ph && word_q[i]);
    end
    core_sel_dec #(.CODE_W(FIELD_W)) u_dec_xcol (
      .en(arr_en), .code(addr_q[XC_HI:0]),
      .sel(x_arr_sel[i*SEL_W +: SEL_W]));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q       <= '0;
      wr_q         <= 1'b0;
      wdata_q      <= '0;
      word_q       <= '0;
      rd_data      <= '0;
      parity_error <= 1'b0;
    end else begin
      if (start) begin
        addr_q  <= req_addr;
        wr_q    <= req_write;
        wdata_q <= req_wdata;
      end
      if (phase == PH_SS && last) begin
        word_q <= wr_q ? {^wdata_q, wdata_q} : sense_bits;
      end
      if (phase == PH_RC && last) begin
        rd_data      <= wr_q ? '0 : word_q[DATA_W-1:0];
        parity_error <= !wr_q && (^word_q);
      end
    end
  end

  assert_onehot_R11: assert property (@(posedge clk) disable iff (rst)
    $onehot0(y_row_sel) && $onehot0(y_col_sel) && $onehot0(y_vec_sel)
    && $onehot0(x_row_sel) && $onehot0(sense_sel));
  assert_sense_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    (sense_sel != '0) |-> (y_row_sel == '0 && x_row_sel == '0));
  assert_dir_end_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(y_dir) |-> (y_row_sel == '0 && x_arr_sel == '0));
  assert_spare_off_R12: assert property (@(posedge clk) disable iff (rst)
    x_arr_sel[SPARE*SEL_W +: SEL_W] == '0);
  assert_ready_drop_R1: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);
  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (y_row_sel == '0 && x_row_sel == '0 && sense_sel == '0));
endmodule

// File: tb/core_cycle_ctrl_bench.sv
module core_cycle_ctrl_bench;
  localparam int TOTAL = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [14:0] req_addr = '0;
  logic [17:0] req_wdata = '0;
  logic req_ready, done, parity_error, y_dir;
  logic [17:0] rd_data;
  logic [7:0] y_row_sel, y_col_sel, y_vec_sel, x_row_sel, sense_sel;
  logic [159:0] x_arr_sel;
  logic [18:0] sense_bits;

  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  core_cycle_ctrl u_core_cycle_ctrl (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .done(done), .rd_data(rd_data), .parity_error(parity_error),
    .y_row_sel(y_row_sel), .y_col_sel(y_col_sel), .y_vec_sel(y_vec_sel),
    .y_dir(y_dir), .x_row_sel(x_row_sel), .x_arr_sel(x_arr_sel),
    .sense_sel(sense_sel), .sense_bits(sense_bits));

  // core store model: read drive clears, write drive sets
  logic [19:0] mem [int];
  logic [19:0] sensed;
  logic [2:0]  seen_row, rd_col_raw, wr_col_raw;
  logic [14:0] rd_obs;
  logic [19:0] rd_mask, wr_mask;
  logic [7:0]  sense_obs;
  logic        rd_seen, dir_bad;
  int          bad_onehot = 0, overlap = 0, idle_act = 0;

  function automatic logic [2:0] idx8(input logic [7:0] v);
    for (int i = 0; i < 8; i++) if (v[i]) return 3'(i);
    return 3'd0;
  endfunction

  function automatic logic [19:0] get(input int a);
    return mem.exists(a) ? mem[a] : 20'd0;
  endfunction

  assign sense_bits = (sense_sel == (8'd1 << seen_row)) ? sensed[18:0] : 19'd0;

  always @(posedge clk) begin
    logic [19:0] m;
    logic [19:0] w;
    int a;
    for (int i = 0; i < 20; i++) m[i] = |x_arr_sel[i*8 +: 8];
    if (req_valid && req_ready) begin
      sensed <= '0; rd_seen <= 1'b0; dir_bad <= 1'b0;
      rd_mask <= '0; wr_mask <= '0; sense_obs <= '0;
      rd_obs <= '0; rd_col_raw <= '0; wr_col_raw <= '0;
    end else if (!rst) begin
      if ($countones(y_row_sel) > 1 || $countones(y_col_sel) > 1 ||
          $countones(y_vec_sel) > 1 || $countones(x_row_sel) > 1 ||
          $countones(sense_sel) > 1) bad_onehot++;
      for (int i = 0; i < 20; i++)
        if ($countones(x_arr_sel[i*8 +: 8]) > 1) bad_onehot++;
      if (req_ready && (y_row_sel != 0 || x_row_sel != 0 || x_arr_sel != 0 ||
                        sense_sel != 0)) idle_act++;
      if (y_row_sel != 0) begin
        if (!y_dir) begin
          a = int'({idx8(y_row_sel), idx8(y_col_sel), idx8(y_vec_sel),
                    idx8(x_row_sel), idx8(x_arr_sel[7:0])});
          w = get(a);
          sensed <= sensed | (w & m);
          mem[a] = w & ~m;
          rd_obs <= 15'(a); rd_seen <= 1'b1; rd_mask <= m;
          rd_col_raw <= idx8(y_col_sel); seen_row <= idx8(y_row_sel);
        end else begin
          if (!rd_seen) dir_bad <= 1'b1;
          for (int i = 0; i < 20; i++) if (m[i]) begin
            a = int'({idx8(y_row_sel), idx8(y_col_sel) ^ 3'd1, idx8(y_vec_sel),
                      idx8(x_row_sel), idx8(x_arr_sel[i*8 +: 8])});
            mem[a] = get(a) | (20'd1 << i);
          end
          wr_mask <= m; wr_col_raw <= idx8(y_col_sel);
        end
      end
      if (sense_sel != 0) begin
        sense_obs <= sense_sel;
        if (y_row_sel != 0 || x_row_sel != 0) overlap++;
      end
    end
  end

  int          lat;
  logic [17:0] got_data;
  logic        got_perr, ready_after;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic access(input logic w, input logic [14:0] a, input logic [17:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    @(posedge clk);
    #1 req_valid = 1'b0;
    ready_after = req_ready;
    lat = 0;
    while (!done && lat < 100) begin
      @(posedge clk); #1; lat++;
    end
    got_data = rd_data; got_perr = parity_error;
  endtask

  function automatic logic [19:0] stored(input logic [17:0] d);
    return {1'b0, ^d, d};
  endfunction

  task automatic t_reset;
    #1;
    chk(req_ready && !done, "R1 reset ready/done", {req_ready, done}, 2'b10);
    chk(y_row_sel == 0 && y_col_sel == 0 && y_vec_sel == 0 && x_row_sel == 0 &&
        x_arr_sel == 0 && sense_sel == 0, "R11 reset selects zero",
        {y_row_sel, x_row_sel}, 0);
  endtask

  task automatic t_write_read(input logic [14:0] a, input logic [17:0] d);
    access(1'b1, a, d);
    chk(lat == TOTAL, "R1 write latency", lat, TOTAL);
    chk(!ready_after, "R1 ready drops after accept", ready_after, 0);
    chk(get(int'(a)) == stored(d), "R9 stored word with parity",
        get(int'(a)), stored(d));
    chk(wr_mask == stored(d), "R6 write enables follow data+parity",
        wr_mask, stored(d));
    chk(wr_col_raw == (a[11:9] ^ 3'd1), "R5 write column crossover",
        wr_col_raw, a[11:9] ^ 3'd1);
    chk(!dir_bad, "R4 read drive precedes write drive", dir_bad, 0);
    chk(!got_perr, "R10 no parity error on write", got_perr, 0);
    access(1'b0, a, 18'd0);
    chk(got_data == d, "R8 read data", got_data, d);
    chk(!got_perr, "R10 clean read no parity error", got_perr, 0);
    chk(rd_obs == a, "R2 R3 read address from selects", rd_obs, a);
    chk(rd_col_raw == a[11:9], "R5 read column not crossed", rd_col_raw, a[11:9]);
    chk(rd_mask == 20'h7FFFF, "R6 read enables arrays 0..18", rd_mask, 20'h7FFFF);
    chk(sense_obs == (8'd1 << a[14:12]), "R7 sense group", sense_obs,
        8'd1 << a[14:12]);
    access(1'b0, a, 18'd0);
    chk(got_data == d, "R8 restore after read", got_data, d);
  endtask

  task automatic t_overwrite;
    t_write_read(15'h1234, 18'h3FFFF);
    access(1'b1, 15'h1234, 18'h00A05);
    access(1'b0, 15'h1234, 18'd0);
    chk(got_data == 18'h00A05, "R9 overwrite clears old bits", got_data, 18'h00A05);
    access(1'b1, 15'h1234, 18'd0);
    chk(wr_mask == 0, "R6 zero data no write enable", wr_mask, 0);
    access(1'b0, 15'h1234, 18'd0);
    chk(got_data == 0 && !got_perr, "R9 zero word read", got_data, 0);
  endtask

  task automatic t_parity;
    access(1'b1, 15'h5A3C, 18'h12345);
    mem[int'(15'h5A3C)] = get(int'(15'h5A3C)) ^ 20'h00020;
    access(1'b0, 15'h5A3C, 18'd0);
    chk(got_perr, "R10 flipped bit flags parity", got_perr, 1);
    chk(got_data == (18'h12345 ^ 18'h20), "R10 corrupted data returned",
        got_data, 18'h12345 ^ 18'h20);
    access(1'b0, 15'h5A3C, 18'd0);
    chk(got_perr, "R10 bad word restored unchanged", got_perr, 1);
  endtask

  task automatic t_spare;
    access(1'b1, 15'h0777, 18'h1FFFF);
    mem[int'(15'h0777)] = get(int'(15'h0777)) | 20'h80000;
    access(1'b0, 15'h0777, 18'd0);
    chk(got_data == 18'h1FFFF && !got_perr, "R12 spare ignored on read",
        {got_perr, got_data}, 18'h1FFFF);
    chk(rd_mask[19] == 1'b0 && wr_mask[19] == 1'b0, "R12 spare never selected",
        {rd_mask[19], wr_mask[19]}, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    t_reset;
    t_write_read(15'h0000, 18'h2AAAA);
    t_write_read(15'h7FFF, 18'h15555);
    t_write_read(15'h4C6B, 18'h00001);
    t_overwrite;
    t_parity;
    t_spare;
    @(negedge clk);
    chk(y_row_sel == 0 && x_arr_sel == 0 && sense_sel == 0 && req_ready,
        "R11 selects zero after cycle", y_row_sel, 0);
    chk(bad_onehot == 0, "R11 one-hot groups", bad_onehot, 0);
    chk(idle_act == 0, "R11 no select while idle", idle_act, 0);
    chk(overlap == 0, "R7 sense apart from drive", overlap, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    checks++; errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule